// File: doc/BRIEF.md
# Atomic Write Signature Filter

This block keeps, for one core, a compact summary of every address the core has stored to while inside an atomic section. The summary is a 256-bit Bloom filter. Two independent hashes of the word address each pick one filter bit. An atomic store sets both bits. An atomic load asks whether both bits of its own address are set. A hit means the core's cached copy of that word may be stale, so the core must drop that copy and refetch before use. The answer is combinational, so the cache pipeline can use it in the same cycle as the load.

When the core hands a lock to the next holder, the whole vector goes out with the lock message and the local copy is wiped. The receiving core ORs the incoming vector into its own in one cycle. Redundant invalidations are avoided in two ways. A word the core owns (registered) is never invalidated. A per-word touched flag marks words already checked once in the current critical section; the flags are cleared when the next critical section opens.

Top module: `atomic_wsig`

## Requirements
- R1: After reset, `sigOut` is all zeros, `needInval` is low, and every touched flag is clear.
- R2: A store with `storeValid` and `storeAtomic` high sets two filter bits. Each bit is found as follows: multiply the 16-bit address by K (K=1 for the first hash, K=0x9E37 for the second), keep the low 16 bits, and XOR the high byte with the low byte. Both bits are visible on `sigOut` one cycle later.
- R3: A store with `storeAtomic` low leaves the filter unchanged.
- R4: In the cycle of an atomic load (`loadValid` and `loadAtomic` high) that is neither registered nor touched, `needInval` is 1 exactly when both of the load address's filter bits are set.
- R5: An atomic store and an atomic load to the same address in the same cycle report a hit for that load.
- R6: A load with `loadRegistered` high never raises `needInval`.
- R7: Every atomic load sets the touched flag of word index `loadAddr[5:0]` at the clock edge. Later atomic loads whose index has its flag set do not raise `needInval`.
- R8: `csStart` clears all touched flags at the edge. If an atomic load sets a flag in that same cycle, the clear wins.
- R9: `sigOut` always shows the current vector. `exportReq` empties the vector at the edge. An atomic store or an import in the same cycle still lands in the emptied vector.
- R10: When `importValid` is high, `importSig` is ORed into the vector at the next edge.
- R11: A load with `loadAtomic` low never raises `needInval`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| storeValid | input | 1 | A store is issued this cycle |
| storeAtomic | input | 1 | The store targets an atomic region |
| storeAddr | input | 16 | Word address of the store |
| loadValid | input | 1 | A load is issued this cycle |
| loadAtomic | input | 1 | The load targets an atomic region |
| loadRegistered | input | 1 | The loaded word is held in registered state |
| loadAddr | input | 16 | Word address of the load |
| needInval | output | 1 | The cached copy must be self-invalidated |
| exportReq | input | 1 | Lock handoff: ship `sigOut` and empty the vector |
| sigOut | output | 256 | Current signature vector |
| importValid | input | 1 | A received signature is present |
| importSig | input | 256 | Signature that arrived with a lock |
| csStart | input | 1 | A new critical section begins |

## Verification
The query path is exercised with loads to addresses that were inserted, addresses never inserted, and addresses stored in the same cycle. Together these separate a correct two-bit AND test from a single-bit test and from a missing store-to-load forward. Repeated loads before and after `csStart`, including a load in the same cycle as `csStart`, separate correct touched-flag priority from a clear that loses to a set. Random mixes of stores, exports, sparse imports and registered or non-atomic loads over a small address pool produce many aliased hits. Each cycle's `needInval` and `sigOut` are compared with a bench model, which exposes wrong hash folding, a lost same-cycle insert at export, and a non-atomic store that leaks into the filter.

// File: rtl/wsig_pkg.sv
package wsig_pkg;

  typedef struct packed {
    logic doInsert;
    logic doQuery;
    logic doExport;
    logic doImport;
    logic touchSet;
    logic touchClr;
  } sigCtrl_t;

endpackage

// File: rtl/wsig_hash.sv
module wsig_hash #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter logic [ADDR_W-1:0] MULT = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int FOLDS = (ADDR_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W = FOLDS * IDX_W;

  logic [ADDR_W-1:0] prod;
  logic [PAD_W-1:0]  padded;

  always_comb begin
    prod = addr * MULT;
    padded = '0;
    padded[ADDR_W-1:0] = prod;
    idx = '0;
    for (int f = 0; f < FOLDS; f++) begin
      idx = idx ^ padded[f*IDX_W +: IDX_W];
    end
  end
endmodule

// File: rtl/wsig_datapath.sv
module wsig_datapath
  import wsig_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SIG_BITS    = 256,
  parameter int TOUCH_WORDS = 64,
  parameter int NUM_HASH    = 2,
  parameter logic [31:0] HASH_MULT = 32'h0000_9E37
) (
  input  logic                clk,
  input  logic                rstN,
  input  sigCtrl_t            ctrl,
  input  logic [ADDR_W-1:0]   storeAddr,
  input  logic [ADDR_W-1:0]   loadAddr,
  input  logic [SIG_BITS-1:0] importSig,
  output logic [SIG_BITS-1:0] sigBits,
  output logic                queryHit,
  output logic                touchedHit
);
  localparam int IDX_W  = $clog2(SIG_BITS);
  localparam int TIDX_W = $clog2(TOUCH_WORDS);

  logic [IDX_W-1:0]       stIdx [NUM_HASH];
  logic [IDX_W-1:0]       ldIdx [NUM_HASH];
  logic [SIG_BITS-1:0]    sigQ, sigD, insMask, effVec;
  logic [TOUCH_WORDS-1:0] touchQ;
  logic [TIDX_W-1:0]      tIdx;

  // one hash pair per function, shared shape, distinct multipliers
  for (genvar g = 0; g < NUM_HASH; g++) begin : gHash
    localparam logic [ADDR_W-1:0] K = (g == 0) ? ADDR_W'(1) : ADDR_W'(HASH_MULT * (2 * g - 1));
    wsig_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .MULT(K)) stHash (
      .addr(storeAddr), .idx(stIdx[g]));
    wsig_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .MULT(K)) ldHash (
      .addr(loadAddr),  .idx(ldIdx[g]));
  end

  always_comb begin
    insMask = '0;
    if (ctrl.doInsert) begin
      for (int g = 0; g < NUM_HASH; g++) insMask[stIdx[g]] = 1'b1;
    end
  end

  // same-cycle insert is forwarded into the query
  assign effVec = sigQ | insMask;

  always_comb begin
    queryHit = 1'b1;
    for (int g = 0; g < NUM_HASH; g++) queryHit = queryHit & effVec[ldIdx[g]];
  end

  always_comb begin
    sigD = ctrl.doExport ? '0 : sigQ;
    sigD = sigD | insMask;
    if (ctrl.doImport) sigD = sigD | importSig;
  end

  always_ff @(posedge clk) begin
    if (!rstN) sigQ <= '0;
    else       sigQ <= sigD;
  end

  assign tIdx = loadAddr[TIDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)              touchQ <= '0;
    else if (ctrl.touchClr) touchQ <= '0;
    else if (ctrl.touchSet) touchQ[tIdx] <= 1'b1;
  end

  assign touchedHit = touchQ[tIdx];
  assign sigBits    = sigQ;
endmodule

// File: rtl/wsig_ctrl.sv
module wsig_ctrl
  import wsig_pkg::*;
(
  input  logic     storeValid,
  input  logic     storeAtomic,
  input  logic     loadValid,
  input  logic     loadAtomic,
  input  logic     loadRegistered,
  input  logic     exportReq,
  input  logic     importValid,
  input  logic     csStart,
  input  logic     queryHit,
  input  logic     touchedHit,
  output sigCtrl_t ctrl,
  output logic     needInval
);
  always_comb begin
    ctrl.doInsert = storeValid & storeAtomic;
    ctrl.doQuery  = loadValid & loadAtomic;
    ctrl.touchSet = loadValid & loadAtomic;
    ctrl.touchClr = csStart;
    ctrl.doExport = exportReq;
    ctrl.doImport = importValid;
  end

  assign needInval = ctrl.doQuery & ~loadRegistered & ~touchedHit & queryHit;
endmodule

// File: rtl/atomic_wsig.sv
module atomic_wsig
  import wsig_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SIG_BITS    = 256,
  parameter int TOUCH_WORDS = 64,
  parameter logic [31:0] HASH_MULT = 32'h0000_9E37
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                storeValid,
  input  logic                storeAtomic,
  input  logic [ADDR_W-1:0]   storeAddr,
  input  logic                loadValid,
  input  logic                loadAtomic,
  input  logic                loadRegistered,
  input  logic [ADDR_W-1:0]   loadAddr,
  output logic                needInval,
  input  logic                exportReq,
  output logic [SIG_BITS-1:0] sigOut,
  input  logic                importValid,
  input  logic [SIG_BITS-1:0] importSig,
  input  logic                csStart
);
  sigCtrl_t ctrl;
  logic     queryHit, touchedHit;

  wsig_ctrl uCtrl (
    .storeValid(storeValid), .storeAtomic(storeAtomic),
    .loadValid(loadValid), .loadAtomic(loadAtomic),
    .loadRegistered(loadRegistered), .exportReq(exportReq),
    .importValid(importValid), .csStart(csStart),
    .queryHit(queryHit), .touchedHit(touchedHit),
    .ctrl(ctrl), .needInval(needInval));

  wsig_datapath #(
    .ADDR_W(ADDR_W), .SIG_BITS(SIG_BITS), .TOUCH_WORDS(TOUCH_WORDS),
    .NUM_HASH(2), .HASH_MULT(HASH_MULT)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .storeAddr(storeAddr), .loadAddr(loadAddr), .importSig(importSig),
    .sigBits(sigOut), .queryHit(queryHit), .touchedHit(touchedHit));
endmodule

// File: rtl/wsig_chk.sv
module wsig_chk #(
  parameter int ADDR_W      = 16,
  parameter int SIG_BITS    = 256,
  parameter int TOUCH_WORDS = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                storeValid,
  input logic                storeAtomic,
  input logic                loadValid,
  input logic                loadAtomic,
  input logic                loadRegistered,
  input logic [ADDR_W-1:0]   loadAddr,
  input logic                needInval,
  input logic                exportReq,
  input logic [SIG_BITS-1:0] sigOut,
  input logic                importValid,
  input logic [SIG_BITS-1:0] importSig,
  input logic                csStart
);
  localparam int TIDX_W = $clog2(TOUCH_WORDS);

  // R3
  plain_store_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(storeValid && storeAtomic) && !importValid && !exportReq) |=> $stable(sigOut));

  // R2
  no_bit_loss_chk: assert property (@(posedge clk) disable iff (!rstN)
    !exportReq |=> ((sigOut & $past(sigOut)) == $past(sigOut)));

  // R10
  import_merge_chk: assert property (@(posedge clk) disable iff (!rstN)
    importValid |=> ((sigOut & $past(importSig)) == $past(importSig)));

  // R9
  export_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (exportReq && !(storeValid && storeAtomic) && !importValid) |=> (sigOut == '0));

  // R6
  registered_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadRegistered |-> !needInval);

  // R11
  nonatomic_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    needInval |-> (loadValid && loadAtomic));

  // R7
  touched_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && loadAtomic && $past(loadValid && loadAtomic && !csStart)
     && (loadAddr[TIDX_W-1:0] == $past(loadAddr[TIDX_W-1:0]))) |-> !needInval);
endmodule

bind atomic_wsig wsig_chk #(
  .ADDR_W(ADDR_W), .SIG_BITS(SIG_BITS), .TOUCH_WORDS(TOUCH_WORDS)
) uChk (
  .clk(clk), .rstN(rstN), .storeValid(storeValid), .storeAtomic(storeAtomic),
  .loadValid(loadValid), .loadAtomic(loadAtomic), .loadRegistered(loadRegistered),
  .loadAddr(loadAddr), .needInval(needInval), .exportReq(exportReq),
  .sigOut(sigOut), .importValid(importValid), .importSig(importSig),
  .csStart(csStart));

// File: tb/atomic_wsig_test.sv
`timescale 1ns/1ps
module atomic_wsig_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         storeValid = 0, storeAtomic = 0, loadValid = 0, loadAtomic = 0;
  logic         loadRegistered = 0, exportReq = 0, importValid = 0, csStart = 0;
  logic [15:0]  storeAddr = '0, loadAddr = '0;
  logic [255:0] importSig = '0;
  logic         needInval;
  logic [255:0] sigOut;

  int checks = 0;
  int fails  = 0;

  bit [255:0] expBits = '0;
  bit [63:0]  expTouch = '0;

  always #2 clk = ~clk;

  atomic_wsig uut (
    .clk(clk), .rstN(rstN), .storeValid(storeValid), .storeAtomic(storeAtomic),
    .storeAddr(storeAddr), .loadValid(loadValid), .loadAtomic(loadAtomic),
    .loadRegistered(loadRegistered), .loadAddr(loadAddr), .needInval(needInval),
    .exportReq(exportReq), .sigOut(sigOut), .importValid(importValid),
    .importSig(importSig), .csStart(csStart));

  // hash as stated in R2
  function automatic int hashIdx(input bit [15:0] a, input int which);
    int unsigned p;
    p = (which == 0) ? a : ((a * 32'h9E37) & 32'hFFFF);
    return int'((p >> 8) ^ (p & 8'hFF));
  endfunction

  function automatic bit [255:0] maskOf(input bit [15:0] a);
    bit [255:0] m = '0;
    m[hashIdx(a, 0)] = 1'b1;
    m[hashIdx(a, 1)] = 1'b1;
    return m;
  endfunction

  task automatic chkBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s needInval actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic chkVec(input string tag, input logic [255:0] act, input bit [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s sigOut actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle at negedge, check query, model the edge, check vector
  task automatic step(input bit sv, input bit sa, input bit [15:0] sadr,
                      input bit lv, input bit la, input bit lr, input bit [15:0] ladr,
                      input bit ex, input bit im, input bit [255:0] isig, input bit cs,
                      input string qTag, input string vTag);
    bit [255:0] ins, eff;
    bit expInv;
    storeValid = sv; storeAtomic = sa; storeAddr = sadr;
    loadValid = lv; loadAtomic = la; loadRegistered = lr; loadAddr = ladr;
    exportReq = ex; importValid = im; importSig = isig; csStart = cs;
    #1;
    ins = (sv && sa) ? maskOf(sadr) : '0;
    eff = expBits | ins;
    expInv = lv && la && !lr && !expTouch[ladr[5:0]] &&
             eff[hashIdx(ladr, 0)] && eff[hashIdx(ladr, 1)];
    chkBit(qTag, needInval, expInv);
    expBits = (ex ? '0 : expBits) | ins | (im ? isig : '0);
    if (cs) expTouch = '0;
    else if (lv && la) expTouch[ladr[5:0]] = 1'b1;
    @(posedge clk); #1;
    chkVec(vTag, sigOut, expBits);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit [15:0]  pool [12];
    bit [255:0] sig;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chkVec("R1", sigOut, '0);
    chkBit("R1", needInval, 1'b0);
    @(negedge clk);

    step(1,1,16'h1234, 0,0,0,16'h0, 0,0,'0,0, "R1", "R2");  // atomic insert A
    step(1,0,16'h4321, 0,0,0,16'h0, 0,0,'0,0, "R3", "R3");  // plain store ignored
    step(0,0,16'h0, 1,1,0,16'h1234, 0,0,'0,0, "R4", "R4");  // hit on A
    step(0,0,16'h0, 1,1,0,16'h1234, 0,0,'0,0, "R7", "R7");  // touched, quiet
    step(0,0,16'h0, 1,1,0,16'h5678, 0,0,'0,0, "R4", "R4");  // not inserted
    step(1,1,16'h0ABC, 1,1,0,16'h0ABC, 0,0,'0,0, "R5", "R5"); // same-cycle forward
    step(1,1,16'h1111, 0,0,0,16'h0, 0,0,'0,0, "R2", "R2");
    step(0,0,16'h0, 1,1,1,16'h1111, 0,0,'0,0, "R6", "R6");  // registered
    step(0,0,16'h0, 1,1,0,16'h1234, 0,0,'0,1, "R8", "R8");  // clear wins over set
    step(0,0,16'h0, 1,1,0,16'h1234, 0,0,'0,0, "R8", "R8");  // hit again after clear
    step(1,1,16'h2222, 0,0,0,16'h0, 0,0,'0,0, "R2", "R2");
    step(0,0,16'h0, 1,0,0,16'h2222, 0,0,'0,0, "R11", "R11"); // plain load quiet
    step(0,0,16'h0, 0,0,0,16'h0, 1,0,'0,0, "R9", "R9");     // export empties
    chkVec("R9", sigOut, '0);
    step(1,1,16'h3333, 0,0,0,16'h0, 1,0,'0,0, "R9", "R9");  // insert survives export
    sig = '0; sig[7] = 1; sig[200] = 1; sig[255] = 1;
    step(0,0,16'h0, 0,0,0,16'h0, 0,1,sig,0, "R10", "R10");
    step(0,0,16'h0, 0,0,0,16'h0, 1,1,sig,0, "R10", "R10");  // import with export

    for (int i = 0; i < 12; i++) pool[i] = 16'($urandom);
    for (int n = 0; n < 3000; n++) begin
      bit [255:0] rs;
      for (int w = 0; w < 8; w++) rs[w*32 +: 32] = $urandom & $urandom & $urandom & $urandom;
      step(($urandom % 10) < 4, ($urandom % 10) < 7, pool[$urandom % 12],
           ($urandom % 10) < 6, ($urandom % 10) < 7, ($urandom % 10) < 2,
           pool[$urandom % 12],
           ($urandom % 40) == 0, ($urandom % 40) == 0, rs, ($urandom % 20) == 0,
           "R4", "R2");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule